// File: doc/BRIEF.md
# Vertical Sync Generator with Retrigger Protection

This block produces the vertical sync pulse of a character-based video timing controller. The horizontal and row counters live elsewhere. The block receives their current values, together with a strobe when the row count is updated and a strobe on the last character of each line. It also has a small register write port carrying three settings:

- the row at which sync should start,
- the pulse width in scanlines,
- the horizontal total.

A sync request exists whenever the row count equals the programmed sync row. The block acts on that request only when the equality newly appears, either through a row update or through a write to the sync-row register. It ignores requests while a pulse is already running. A mid-line write that creates the equality either starts the pulse at once or suppresses it for that field. Which of the two happens depends on the horizontal position at which the write lands.

All state advances on a character-clock enable. The pulse is timed in scanlines by counting line wraps. A pulse that starts mid-line is stretched by the unfinished part of the line on which it started.

Top module: `vsync_unit`

## Requirements
- R1: A synchronous reset drives `vsync` low and clears the pulse timer and the equality history. `vsync` stays low until an equality newly appears.
- R2: Register writes and all other state changes take effect only on cycles with `cen` high. `wr_sel` selects the register: 0 is the sync row (low bits of `wr_data`), 1 is the width (low 4 bits), 2 is the horizontal total.
- R3: When a `row_inc` cycle makes `row` newly equal to the sync row, `vsync` goes high on the following cycle. It stays high through the `hwrap` cycle of the W-th line wrap, where W is the programmed width.
- R4: A programmed width of 0 gives a pulse of 16 scanlines.
- R5: An equality that persists never starts a second pulse. This includes repeated `row_inc` strobes that carry an unchanged row value.
- R6: An equality that newly appears while `vsync` is high starts no pulse and does not restart the running one. Once that pulse ends, the same equality still starts nothing.
- R7: A write of the sync row that makes it equal to `row` on a cycle with `hcount` of 2 or more (and no `row_inc`) starts the pulse at once. `vsync` goes high on the next cycle.
- R8: A pulse started by such a write is not shortened by the wrap that ends its own line, unless the write landed on that wrap cycle. Measured in character cycles from the trigger character inclusive, the pulse lasts (htotal − hcount + 1) + W·(htotal + 1). Here `hwrap` marks `hcount` equal to htotal.
- R9: A sync-row write that makes the equality with `hcount` below 2 (and no `row_inc`) starts no pulse. The equality is marked as seen, so nothing fires while it persists.
- R10: The blocked state ends when an update leaves `row` unequal to the sync row, through a row change or a sync-row write. A later new equality then starts a pulse.
- R11: A sync-row write and a `row_inc` on the same cycle count as one change, judged against the new row and the new register value. If equal, the pulse starts as a row-increment start, whatever `hcount` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cen | input | 1 | Character-clock enable |
| hcount | input | HCW (8) | Current horizontal character count |
| row | input | RCW (5) | Current character-row count |
| row_inc | input | 1 | Row count updated this character |
| hwrap | input | 1 | Last character of the line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 sync row, 1 width, 2 horizontal total |
| wr_data | input | DW (8) | Register write data |
| vsync | output | 1 | Vertical sync pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit horizontal count, a 5-bit row count and a 4-bit width field. It programs a 16-character line and an 8-row frame with two scanlines per row, so a full field passes in 256 characters. The 4-bit width field makes the zero-means-16 case reachable, and a 16-scanline pulse then covers an entire field and runs straight into the next trigger. The short line lets the horizontal-phase boundary at 2 and the wrap-cycle trigger both be hit exactly. A zero vertical total keeps the row fixed, which exercises persisting equality.

// File: rtl/vsu_pkg.sv
package vsu_pkg;

  typedef enum logic [1:0] {
    SEL_POS  = 2'd0,
    SEL_WID  = 2'd1,
    SEL_HTOT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Scanlines a width code stands for: code 0 means the full field range.
  function automatic int eff_lines(input int code, input int width_bits);
    return (code == 0) ? (1 << width_bits) : code;
  endfunction

  // Characters from the trigger character (inclusive) to the last high one.
  function automatic int span_chars(input int lines, input int htot,
                                    input int hpos, input bit mid);
    return (htot - hpos + 1) + (mid ? lines : lines - 1) * (htot + 1);
  endfunction

endpackage

// File: rtl/vsu_regs.sv
module vsu_regs
  import vsu_pkg::*;
#(
  parameter int RCW = 5,
  parameter int SWW = 4,
  parameter int HCW = 8,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cen,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  output logic [RCW-1:0] pos_q,
  output logic [RCW-1:0] pos_next,
  output logic           pos_wr,
  output logic [SWW-1:0] wid_q,
  output logic [HCW-1:0] htot_q,
  output logic           cfg_wr
);

  logic wid_wr, htot_wr;

  assign pos_wr   = cen & wr_en & (wr_sel == SEL_POS);
  assign wid_wr   = cen & wr_en & (wr_sel == SEL_WID);
  assign htot_wr  = cen & wr_en & (wr_sel == SEL_HTOT);
  assign cfg_wr   = wid_wr | htot_wr;
  // Value the comparator judges against: the written one if a write lands now.
  assign pos_next = pos_wr ? wr_data[RCW-1:0] : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      wid_q  <= '0;
      htot_q <= '0;
    end else begin
      if (pos_wr)  pos_q  <= wr_data[RCW-1:0];
      if (wid_wr)  wid_q  <= wr_data[SWW-1:0];
      if (htot_wr) htot_q <= wr_data[HCW-1:0];
    end
  end

  assert_write_needs_cen_R2: assert property (@(posedge clk) disable iff (rst)
    !cen |=> ($stable(pos_q) && $stable(wid_q) && $stable(htot_q)));

endmodule

// File: rtl/vsu_cmp.sv
module vsu_cmp #(
  parameter int RCW        = 5,
  parameter int HCW        = 8,
  parameter int TRIG_MIN_H = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cen,
  input  logic [RCW-1:0] row,
  input  logic           row_inc,
  input  logic [HCW-1:0] hcount,
  input  logic [RCW-1:0] pos_next,
  input  logic           pos_wr,
  input  logic           active,
  output logic           fire,
  output logic           fire_mid
);

  logic seen_q, blocked_q;
  logic evt, eq_now, newly, write_only, early, block_now;

  assign evt        = cen & (row_inc | pos_wr);
  assign eq_now     = (row == pos_next);
  assign newly      = evt & eq_now & ~seen_q;
  assign write_only = pos_wr & ~row_inc;
  assign early      = (hcount < HCW'(TRIG_MIN_H));
  assign fire       = newly & ~active & ~(write_only & early);
  assign fire_mid   = fire & write_only;
  assign block_now  = newly & ~active & write_only & early;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      if (evt) seen_q <= eq_now;
      if (evt && !eq_now) blocked_q <= 1'b0;
      else if (block_now) blocked_q <= 1'b1;
    end
  end

  assert_blocked_is_seen_R9: assert property (@(posedge clk) disable iff (rst)
    blocked_q |-> seen_q);
  assert_blocked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    blocked_q |-> !fire);
  assert_unblock_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(blocked_q) |-> ($past(row) != $past(pos_next)));

endmodule

// File: rtl/vsu_timer.sv
module vsu_timer #(
  parameter int SWW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cen,
  input  logic           hwrap,
  input  logic           fire,
  input  logic           fire_mid,
  input  logic [SWW-1:0] wid,
  output logic           active
);

  localparam int CW = SWW + 1;

  logic [CW-1:0] cnt_q, cnt_inc, eff;
  logic          skip_q;

  assign eff     = (wid == '0) ? CW'(1 << SWW) : CW'(wid);
  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (cen) begin
      if (fire) begin
        active <= 1'b1;
        cnt_q  <= '0;
        // A mid-line start lets the wrap of its own line pass uncounted.
        skip_q <= fire_mid & ~hwrap;
      end else if (active && hwrap) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (cnt_inc >= eff) begin
          active <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assert_rise_from_trigger_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(fire && cen));
  assert_fall_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(cen && hwrap));
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> (cnt_q >= $past(cnt_q)));
  assert_mid_start_R7: assert property (@(posedge clk) disable iff (rst)
    (cen && fire_mid) |=> active);

endmodule

// File: rtl/vsync_unit.sv
module vsync_unit
  import vsu_pkg::*;
#(
  parameter int HCW = 8,
  parameter int RCW = 5,
  parameter int SWW = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cen,
  input  logic [HCW-1:0] hcount,
  input  logic [RCW-1:0] row,
  input  logic           row_inc,
  input  logic           hwrap,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  output logic           vsync
);

  logic [RCW-1:0] pos_q, pos_next;
  logic [SWW-1:0] wid_q;
  logic [HCW-1:0] htot_q;
  logic           pos_wr, cfg_wr, fire, fire_mid;

  vsu_regs #(.RCW(RCW), .SWW(SWW), .HCW(HCW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cen(cen), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pos_q(pos_q), .pos_next(pos_next), .pos_wr(pos_wr),
    .wid_q(wid_q), .htot_q(htot_q), .cfg_wr(cfg_wr)
  );

  vsu_cmp #(.RCW(RCW), .HCW(HCW), .TRIG_MIN_H(2)) u_cmp (
    .clk(clk), .rst(rst), .cen(cen), .row(row), .row_inc(row_inc),
    .hcount(hcount), .pos_next(pos_next), .pos_wr(pos_wr), .active(vsync),
    .fire(fire), .fire_mid(fire_mid)
  );

  vsu_timer #(.SWW(SWW)) u_timer (
    .clk(clk), .rst(rst), .cen(cen), .hwrap(hwrap), .fire(fire),
    .fire_mid(fire_mid), .wid(wid_q), .active(vsync)
  );

  // Pulse-length checker: counts high characters, compares at the fall.
  int   len_q, exp_q;
  logic track_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= 0;
      exp_q   <= 0;
      track_q <= 1'b0;
    end else if (cen) begin
      if (fire) begin
        len_q   <= 1;
        exp_q   <= span_chars(eff_lines(int'(wid_q), SWW), int'(htot_q),
                              int'(hcount), fire_mid);
        track_q <= 1'b1;
      end else begin
        if (vsync) len_q <= len_q + 1;
        if (cfg_wr) track_q <= 1'b0;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !vsync);
  assert_pulse_length_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(vsync) && track_q) |-> (len_q == exp_q));

endmodule

// File: tb/sim_vsync_unit.sv
module sim_vsync_unit;
  localparam int HCW = 8, RCW = 5, SWW = 4, DW = 8;

  logic clk = 1'b0, rst = 1'b1, cen = 1'b0, row_inc = 1'b0, hwrap = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [HCW-1:0] hcount = '0;
  logic [RCW-1:0] row = '0;
  logic vsync;

  always #4 clk = ~clk;

  vsync_unit #(.HCW(HCW), .RCW(RCW), .SWW(SWW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cen(cen), .hcount(hcount), .row(row),
    .row_inc(row_inc), .hwrap(hwrap), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .vsync(vsync)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  // Bench-side video timing
  int H = 15, lpr = 2, vt = 7, h = 0, r = 0, ln = 0;
  bit rinc_pend = 1'b0, gaps = 1'b0;
  // Behavioural reference
  bit m_vs = 1'b0, m_seen = 1'b0;
  int m_need = 0, m_pos = 0, m_wid = 0, m_exp = 0;
  int hi = 0, pulses = 0, p0 = 0;
  bit prev_vs = 1'b0;

  function automatic int lines_of(input int w);
    return (w == 0) ? 16 : w;
  endfunction

  function automatic bit cen_at(input int c);
    return !(gaps && (c % 4 == 3));
  endfunction

  task automatic chk(input bit ok, input string req, input int act,
                     input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit wr, input int sel, input int data, input bit kill);
    bit ce, ri, hw, start, midl;
    int pn;
    @(negedge clk);
    chk(vsync == m_vs, cur_req, int'(vsync), int'(m_vs), "vsync level");
    if (prev_vs && !vsync) begin
      pulses++;
      chk(hi == m_exp, cur_req, hi, m_exp, "pulse length in characters");
    end
    ce = cen_at(cyc) && !kill;
    if (vsync && ce) hi++;
    prev_vs = vsync;
    ri = ce && (h == 0) && rinc_pend;
    hw = ce && (h == H);
    cen = ce; hcount = HCW'(h); row = RCW'(r); row_inc = ri; hwrap = hw;
    wr_en = wr; wr_sel = 2'(sel); wr_data = DW'(data);
    if (ce) begin
      pn = (wr && sel == 0) ? data % 32 : m_pos;
      start = 1'b0;
      if (ri || (wr && sel == 0)) begin
        if (r == pn && !m_seen && !m_vs && (ri || h >= 2)) start = 1'b1;
        m_seen = (r == pn);
      end
      if (start) begin
        midl   = !ri;
        m_vs   = 1'b1;
        m_need = lines_of(m_wid) + ((midl && !hw) ? 1 : 0);
        m_exp  = (H - h + 1) + (midl ? lines_of(m_wid) : lines_of(m_wid) - 1) * (H + 1) - 1;
        hi     = 0;
      end else if (m_vs && hw) begin
        m_need--;
        if (m_need == 0) m_vs = 1'b0;
      end
      if (wr && sel == 0) m_pos = pn;
      if (wr && sel == 1) m_wid = data % 16;
      if (ri) rinc_pend = 1'b0;
      if (h == H) begin
        h = 0; ln++;
        if (ln >= lpr) begin
          ln = 0; r = (r >= vt) ? 0 : r + 1; rinc_pend = 1'b1;
        end
      end else h++;
    end
    cyc++;
  endtask

  task automatic advance(input int tr, input int tl, input int th);
    while (!(r == tr && ln == tl && h == th && cen_at(cyc))) tick(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vsync == 1'b0, "R1", int'(vsync), 0, "vsync during reset");
    rst = 1'b0;
    // Configuration: sync row 5, width 3, line total 15
    cur_req = "R2";
    tick(1, 0, 5, 0); tick(1, 1, 3, 0); tick(1, 2, 15, 0);
    // R3: normal starts over two fields
    cur_req = "R3"; p0 = pulses;
    repeat (600) tick(0, 0, 0, 0);
    chk(pulses - p0 == 2, "R3", pulses - p0, 2, "normal pulses in two fields");
    // R6: new equality during an active pulse is ignored
    cur_req = "R6";
    advance(5, 0, 4); p0 = pulses;
    advance(6, 0, 8); tick(1, 0, 6, 0);
    advance(7, 0, 3);
    chk(pulses - p0 == 1, "R6", pulses - p0, 1, "pulses with write while active");
    tick(1, 0, 5, 0);
    // R4: width code 0 gives 16 scanlines
    cur_req = "R4";
    advance(1, 0, 3); tick(1, 1, 0, 0); p0 = pulses;
    advance(5, 0, 6);
    advance(2, 0, 4); tick(1, 0, 20, 0);
    advance(5, 0, 6); tick(1, 1, 3, 0);
    chk(pulses - p0 == 1, "R4", pulses - p0, 1, "16-line pulse count");
    advance(6, 0, 4); tick(1, 0, 5, 0);
    // R7/R8: mid-line starts
    cur_req = "R8";
    advance(2, 1, 7); p0 = pulses; tick(1, 0, 2, 0);
    advance(4, 1, 3);
    chk(pulses - p0 == 1, "R7", pulses - p0, 1, "mid-line start at h=7");
    advance(6, 0, 2); p0 = pulses; tick(1, 0, 6, 0);
    advance(0, 1, 15); tick(1, 0, 0, 0);
    advance(2, 1, 3);
    chk(pulses - p0 == 2, "R8", pulses - p0, 2, "starts at h=2 and on the wrap character");
    // R9: write at h=1 blocks the field
    cur_req = "R9";
    advance(3, 0, 1); p0 = pulses; tick(1, 0, 3, 0);
    advance(4, 0, 5);
    chk(pulses - p0 == 0, "R9", pulses - p0, 0, "blocked at h=1");
    // R10: row change unblocks, next field fires
    cur_req = "R10";
    advance(4, 1, 3);
    chk(pulses - p0 == 0, "R10", pulses - p0, 0, "still quiet after row change");
    advance(3, 0, 4);
    advance(4, 1, 3);
    chk(pulses - p0 == 1, "R10", pulses - p0, 1, "start after row-change unblock");
    // R10: write breaking the equality unblocks
    advance(5, 0, 4); tick(1, 0, 9, 0);
    advance(6, 1, 0); p0 = pulses; tick(1, 0, 6, 0);
    advance(6, 1, 5); tick(1, 0, 10, 0);
    chk(pulses - p0 == 0, "R10", pulses - p0, 0, "blocked at h=0 before clearing");
    advance(6, 1, 9); tick(1, 0, 6, 0);
    advance(0, 1, 3);
    chk(pulses - p0 == 1, "R10", pulses - p0, 1, "start after write unblock");
    // R11: simultaneous write and row update at h=0
    cur_req = "R11";
    advance(2, 0, 0); p0 = pulses; tick(1, 0, 2, 0);
    advance(3, 1, 3);
    chk(pulses - p0 == 1, "R11", pulses - p0, 1, "combined change start");
    // R2: write with cen low ignored, character gaps active
    cur_req = "R2"; gaps = 1'b1;
    advance(4, 0, 6); p0 = pulses; tick(1, 0, 4, 1);
    advance(5, 0, 0);
    chk(pulses - p0 == 0, "R2", pulses - p0, 0, "write without cen");
    // R5: fixed row, persisting equality
    cur_req = "R5"; vt = 0;
    advance(0, 0, 6); p0 = pulses; tick(1, 0, 0, 0);
    repeat (400) tick(0, 0, 0, 0);
    chk(pulses - p0 == 1, "R5", pulses - p0, 1, "single pulse with fixed row");
    // R7 then R1: start mid-line, reset during the pulse
    cur_req = "R7";
    tick(1, 0, 3, 0);
    advance(0, 0, 8); tick(1, 0, 0, 0);
    repeat (5) tick(0, 0, 0, 0);
    chk(vsync == 1'b1, "R7", int'(vsync), 1, "vsync high after mid-line write");
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(vsync == 1'b0, "R1", int'(vsync), 0, "vsync after reset");
    summary();
    $finish;
  end
endmodule